// File: doc/BRIEF.md
# DMA Shared Control and Interrupt Collector

This block holds the state that all channels of a 32-channel DMA engine share. A small register port lets software set the global run enable and a throughput-mode bit. Through the same port software reads two sticky fault flags, one for halt and one for bad address. It also reads a per-channel interrupt-pending word, rings per-channel descriptor-fetch doorbells, and programs a per-channel mask word. The mask word is passed straight out to the channels.

Each channel reports three kinds of events: transfer done, halt and address fault. Any of them sets that channel's pending bit, and the single interrupt line is high whenever a pending bit is set. A halt or address fault from any channel also sets the matching sticky flag in the control word. Software clears these bits by writing back a value with zeros in the bits to drop. A write can only clear bits, never set them. An event that arrives in the same cycle as a clearing write wins, so no event is lost. A write of ones to the doorbell word gives a one-cycle fetch pulse to each selected channel, but only while the global enable is set.

Top module: `dma_glb_ctrl`

## Requirements
- R1: After reset, the control word, the pending word and the mask word all read zero, `irq` is low and `fetch_pulse` is zero.
- R2: A done, halt or address-fault event on channel i sets pending bit i. The bit is visible the cycle after the event and stays set with no further stimulus.
- R3: `irq` is high exactly when at least one pending bit is set.
- R4: A write to the pending word (offset 0x1004) ANDs the written data into it. Writing zero clears every bit, and writing ones leaves the bits unchanged.
- R5: An event in the same cycle as a clearing write to the pending word or the control word leaves its bit set.
- R6: A halt event on any channel sets control bit 3, and an address-fault event sets control bit 2. Both are sticky.
- R7: A control write (offset 0x1000) with bit 3 or bit 2 at zero clears that flag. With the bit at one the flag keeps its value, and a write cannot set it.
- R8: A write to the doorbell word (offset 0x100C) while enabled drives `fetch_pulse` equal to the written data for exactly one cycle, starting the cycle after the write. The doorbell word always reads zero.
- R9: While the global enable is low, doorbell writes produce no fetch pulse.
- R10: Control bit 0 (global enable) and bit 31 (throughput mode) are written directly, read back, and drive `glb_en` and `perf_mode`.
- R11: The mask word (offset 0x101C) is read/write and drives `chan_prog_mask`.
- R12: Addresses that are not mapped read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 13 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 13 | Read byte address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| ch_done | input | 32 | Per-channel transfer-done event |
| ch_halt | input | 32 | Per-channel halt event |
| ch_addr_err | input | 32 | Per-channel address-fault event |
| fetch_pulse | output | 32 | Per-channel one-cycle descriptor-fetch request |
| irq | output | 1 | Interrupt, OR of pending bits |
| glb_en | output | 1 | Global enable |
| perf_mode | output | 1 | Throughput-mode bit |
| chan_prog_mask | output | 32 | Per-channel mask word |

## Verification
A write or an event that reaches the block at one rising edge shows up in every register readback, in `irq`, `glb_en`, `perf_mode` and `chan_prog_mask` one cycle later. A doorbell write gives a fetch pulse one cycle later, and the pulse drops the cycle after that. Reads are combinational. Each expected result is queued with the cycle number it falls due, taken from the stimulus cycle plus that lag. The monitor compares it at the falling edge of exactly that cycle, so a result that comes a cycle early or late is reported. Same-cycle collisions between events and clearing writes are driven on purpose to check the priority rules.

// File: rtl/dma_glb_pkg.sv
package dma_glb_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 13;

    // register window byte offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL = 13'h1000;
    localparam logic [ADDR_W-1:0] OFS_PEND = 13'h1004;
    localparam logic [ADDR_W-1:0] OFS_BELL = 13'h100C;
    localparam logic [ADDR_W-1:0] OFS_MASK = 13'h101C;

    // control word bit positions
    localparam int BIT_EN   = 0;
    localparam int BIT_AERR = 2;
    localparam int BIT_HALT = 3;
    localparam int BIT_PERF = 31;

    typedef struct packed {
        logic perf;
        logic halt;
        logic aerr;
        logic en;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PEND,
        SEL_BELL,
        SEL_MASK
    } reg_sel_e;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTRL: decode = SEL_CTRL;
            OFS_PEND: decode = SEL_PEND;
            OFS_BELL: decode = SEL_BELL;
            OFS_MASK: decode = SEL_MASK;
            default:  decode = SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[BIT_EN]   = c.en;
        w[BIT_AERR] = c.aerr;
        w[BIT_HALT] = c.halt;
        w[BIT_PERF] = c.perf;
        return w;
    endfunction

endpackage

// File: rtl/dgc_ctrl.sv
module dgc_ctrl
    import dma_glb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  ctrl_t        wval,
    input  logic [N-1:0] halt_ev,
    input  logic [N-1:0] aerr_ev,
    output ctrl_t        ctrl_q
);
    logic any_halt;
    logic any_aerr;
    ctrl_t ctrl_d;

    assign any_halt = |halt_ev;
    assign any_aerr = |aerr_ev;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d.en   = wval.en;
            ctrl_d.perf = wval.perf;
            ctrl_d.halt = ctrl_q.halt & wval.halt;
            ctrl_d.aerr = ctrl_q.aerr & wval.aerr;
        end
        // event beats a clearing write
        if (any_halt) ctrl_d.halt = 1'b1;
        if (any_aerr) ctrl_d.aerr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    // R6: fault events raise the sticky flags
    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        any_halt |=> ctrl_q.halt);
    a_r6_aerr_sticky: assert property (@(posedge clk) disable iff (rst)
        any_aerr |=> ctrl_q.aerr);
    // R7: a write never raises a flag that was clear without an event
    a_r7_no_set_by_write: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.halt && !any_halt) |=> !ctrl_q.halt);

endmodule

// File: rtl/dgc_pend.sv
module dgc_pend
    import dma_glb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [N-1:0] wmask,
    input  logic [N-1:0] ev,
    output logic [N-1:0] pend_q,
    output logic         irq
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            logic keep;
            assign keep = pend_q[i] & (~wr | wmask[i]);
            always_ff @(posedge clk) begin
                if (rst) pend_q[i] <= 1'b0;
                else     pend_q[i] <= keep | ev[i];
            end
        end
    endgenerate

    assign irq = |pend_q;

    // R2: an event is captured into its pending bit
    a_r2_event_captured: assert property (@(posedge clk) disable iff (rst)
        (|ev) |=> ((pend_q & $past(ev)) == $past(ev)));
    // R4: without a write nothing is lost
    a_r4_hold_no_write: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
    // R4: a write can only clear, bits that rise come from events
    a_r4_rise_from_event: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(ev)) == '0));

endmodule

// File: rtl/dgc_bell.sv
module dgc_bell
    import dma_glb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic         en,
    input  logic [N-1:0] ring,
    output logic [N-1:0] pulse_q
);
    logic [N-1:0] pulse_d;

    assign pulse_d = (wr && en) ? ring : '0;

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= '0;
        else     pulse_q <= pulse_d;
    end

    // R9: disabled controller never requests a fetch
    a_r9_gated_by_enable: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pulse_q == '0));
    // R8: pulses exist only in the cycle after a doorbell write
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
        !wr |=> (pulse_q == '0));

endmodule

// File: rtl/dma_glb_ctrl.sv
module dma_glb_ctrl
    import dma_glb_pkg::*;
#(
    parameter int CH_N = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [CH_N-1:0]     ch_done,
    input  logic [CH_N-1:0]     ch_halt,
    input  logic [CH_N-1:0]     ch_addr_err,
    output logic [CH_N-1:0]     fetch_pulse,
    output logic                irq,
    output logic                glb_en,
    output logic                perf_mode,
    output logic [CH_N-1:0]     chan_prog_mask
);
    localparam int PAD_W = DATA_W - CH_N;

    reg_sel_e     wsel;
    reg_sel_e     rsel;
    ctrl_t        ctrl_q;
    ctrl_t        ctrl_w;
    logic [CH_N-1:0] pend_q;
    logic [CH_N-1:0] mask_q;
    logic [CH_N-1:0] ev_any;

    assign wsel   = wr_en ? decode(wr_addr) : SEL_NONE;
    assign rsel   = decode(rd_addr);
    assign ev_any = ch_done | ch_halt | ch_addr_err;

    assign ctrl_w.en   = wr_data[BIT_EN];
    assign ctrl_w.aerr = wr_data[BIT_AERR];
    assign ctrl_w.halt = wr_data[BIT_HALT];
    assign ctrl_w.perf = wr_data[BIT_PERF];

    dgc_ctrl #(.N(CH_N)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (wsel == SEL_CTRL),
        .wval    (ctrl_w),
        .halt_ev (ch_halt),
        .aerr_ev (ch_addr_err),
        .ctrl_q  (ctrl_q)
    );

    dgc_pend #(.N(CH_N)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .wr     (wsel == SEL_PEND),
        .wmask  (wr_data[CH_N-1:0]),
        .ev     (ev_any),
        .pend_q (pend_q),
        .irq    (irq)
    );

    dgc_bell #(.N(CH_N)) u_bell (
        .clk     (clk),
        .rst     (rst),
        .wr      (wsel == SEL_BELL),
        .en      (ctrl_q.en),
        .ring    (wr_data[CH_N-1:0]),
        .pulse_q (fetch_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst)                    mask_q <= '0;
        else if (wsel == SEL_MASK)  mask_q <= wr_data[CH_N-1:0];
    end

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                case (rsel)
                    SEL_CTRL: rd_data = pack_ctrl(ctrl_q);
                    SEL_PEND: rd_data = {{PAD_W{1'b0}}, pend_q};
                    SEL_MASK: rd_data = {{PAD_W{1'b0}}, mask_q};
                    default:  rd_data = '0;
                endcase
            end
        end else begin : g_full
            always_comb begin
                case (rsel)
                    SEL_CTRL: rd_data = pack_ctrl(ctrl_q);
                    SEL_PEND: rd_data = pend_q;
                    SEL_MASK: rd_data = mask_q;
                    default:  rd_data = '0;
                endcase
            end
        end
    endgenerate

    assign glb_en         = ctrl_q.en;
    assign perf_mode      = ctrl_q.perf;
    assign chan_prog_mask = mask_q;

    // R12: unmapped writes leave the mask word alone
    a_r12_mask_stable: assert property (@(posedge clk) disable iff (rst)
        (wsel != SEL_MASK) |=> $stable(mask_q));
    // R5: an event during a clearing pending write survives
    a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
        ((wsel == SEL_PEND) && (|ev_any)) |=> ((pend_q & $past(ev_any)) == $past(ev_any)));

endmodule

// File: tb/dma_glb_ctrl_test.sv
module dma_glb_ctrl_test;

    localparam int K_RD = 0, K_IRQ = 1, K_FETCH = 2, K_EN = 3, K_PERF = 4, K_MASK = 5;

    typedef struct {
        int          kind;
        logic [12:0] addr;
        logic [31:0] val;
        longint      due;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [12:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] ch_done = '0, ch_halt = '0, ch_addr_err = '0;
    logic [31:0] fetch_pulse;
    logic        irq, glb_en, perf_mode;
    logic [31:0] chan_prog_mask;

    item_t  q[$];
    longint cyc = 0;
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done_flag = 0;

    always #10 clk = ~clk; // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    dma_glb_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ch_done(ch_done), .ch_halt(ch_halt),
        .ch_addr_err(ch_addr_err), .fetch_pulse(fetch_pulse), .irq(irq),
        .glb_en(glb_en), .perf_mode(perf_mode), .chan_prog_mask(chan_prog_mask)
    );

    // driver: apply one cycle of stimulus at a falling edge
    task automatic step(input logic w, input logic [12:0] a, input logic [31:0] d,
                        input logic [31:0] dn, input logic [31:0] ht, input logic [31:0] ae);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d;
        ch_done = dn; ch_halt = ht; ch_addr_err = ae;
    endtask

    task automatic idle();
        step(1'b0, 13'h0, 32'h0, 32'h0, 32'h0, 32'h0);
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        step(1'b1, a, d, 32'h0, 32'h0, 32'h0);
    endtask

    // queue an expectation due 'lag' cycles after the current stimulus
    task automatic expect_v(input int kind, input logic [12:0] a, input logic [31:0] v,
                            input int lag, input string tag);
        item_t it;
        it.kind = kind; it.addr = a; it.val = v; it.due = cyc + lag; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compares due expectations away from the rising edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [31:0] got;
            it = q.pop_front();
            rd_addr = it.addr;
            #1;
            case (it.kind)
                K_RD:    got = rd_data;
                K_IRQ:   got = {31'h0, irq};
                K_FETCH: got = fetch_pulse;
                K_EN:    got = {31'h0, glb_en};
                K_PERF:  got = {31'h0, perf_mode};
                default: got = chan_prog_mask;
            endcase
            n_cmp++;
            if (it.due != cyc || got !== it.val) begin
                n_bad++;
                $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h", it.tag, it.kind,
                         it.addr, got, it.val);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        idle();
        expect_v(K_RD, 13'h1000, 32'h0, 1, "R1 ctrl");
        expect_v(K_RD, 13'h1004, 32'h0, 1, "R1 pend");
        expect_v(K_RD, 13'h101C, 32'h0, 1, "R1 mask");
        expect_v(K_IRQ, 13'h0, 32'h0, 1, "R1 irq");
        expect_v(K_FETCH, 13'h0, 32'h0, 1, "R1 fetch");

        // R10 enable and throughput bit
        wr(13'h1000, 32'h8000_0001);
        expect_v(K_RD, 13'h1000, 32'h8000_0001, 1, "R10 ctrl readback");
        expect_v(K_EN, 13'h0, 32'h1, 1, "R10 glb_en");
        expect_v(K_PERF, 13'h0, 32'h1, 1, "R10 perf_mode");

        // R2 / R3 done event on channel 5
        step(1'b0, 13'h0, 32'h0, 32'h0000_0020, 32'h0, 32'h0);
        expect_v(K_RD, 13'h1004, 32'h0000_0020, 1, "R2 pend set");
        expect_v(K_IRQ, 13'h0, 32'h1, 1, "R3 irq high");
        expect_v(K_RD, 13'h1004, 32'h0000_0020, 2, "R2 pend holds");
        idle();

        // R4 writing ones keeps, zero clears
        wr(13'h1004, 32'hFFFF_FFFF);
        expect_v(K_RD, 13'h1004, 32'h0000_0020, 1, "R4 ones keep");
        wr(13'h1004, 32'h0);
        expect_v(K_RD, 13'h1004, 32'h0, 1, "R4 zero clears");
        expect_v(K_IRQ, 13'h0, 32'h0, 1, "R3 irq low");

        // R5 event collides with clearing write
        step(1'b0, 13'h0, 32'h0, 32'h0000_0008, 32'h0, 32'h0);
        step(1'b1, 13'h1004, 32'h0, 32'h8000_0081, 32'h0, 32'h0);
        expect_v(K_RD, 13'h1004, 32'h8000_0081, 1, "R5 event wins");
        idle();
        wr(13'h1004, 32'h0);
        expect_v(K_RD, 13'h1004, 32'h0, 1, "R4 clear again");

        // R6 sticky fault flags
        step(1'b0, 13'h0, 32'h0, 32'h0, 32'h0000_0200, 32'h0);
        expect_v(K_RD, 13'h1000, 32'h8000_0009, 1, "R6 halt flag");
        expect_v(K_RD, 13'h1004, 32'h0000_0200, 1, "R2 halt sets pend");
        step(1'b0, 13'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0004);
        expect_v(K_RD, 13'h1000, 32'h8000_000D, 1, "R6 aerr flag");
        idle();
        expect_v(K_RD, 13'h1000, 32'h8000_000D, 1, "R6 flags sticky");

        // R7 clear aerr only, keep halt
        wr(13'h1000, 32'h8000_0009);
        expect_v(K_RD, 13'h1000, 32'h8000_0009, 1, "R7 aerr cleared halt kept");
        // R5/R7 halt event during clearing control write
        step(1'b1, 13'h1000, 32'h8000_0001, 32'h0, 32'h0000_0001, 32'h0);
        expect_v(K_RD, 13'h1000, 32'h8000_0009, 1, "R5 halt event wins");
        wr(13'h1000, 32'h8000_0001);
        expect_v(K_RD, 13'h1000, 32'h8000_0001, 1, "R7 halt cleared");
        wr(13'h1000, 32'h8000_000D);
        expect_v(K_RD, 13'h1000, 32'h8000_0001, 1, "R7 write cannot set");
        wr(13'h1004, 32'h0);

        // R8 doorbell pulse
        wr(13'h100C, 32'h0000_F00F);
        expect_v(K_FETCH, 13'h0, 32'h0000_F00F, 1, "R8 pulse");
        expect_v(K_RD, 13'h100C, 32'h0, 1, "R8 doorbell reads zero");
        expect_v(K_FETCH, 13'h0, 32'h0, 2, "R8 pulse one cycle");
        idle();

        // R9 doorbell ignored while disabled
        wr(13'h1000, 32'h0);
        expect_v(K_EN, 13'h0, 32'h0, 1, "R10 enable off");
        wr(13'h100C, 32'hFFFF_FFFF);
        expect_v(K_FETCH, 13'h0, 32'h0, 1, "R9 no pulse");
        expect_v(K_FETCH, 13'h0, 32'h0, 2, "R9 no late pulse");
        idle();

        // R11 mask word
        wr(13'h101C, 32'hA5A5_0F0F);
        expect_v(K_RD, 13'h101C, 32'hA5A5_0F0F, 1, "R11 mask readback");
        expect_v(K_MASK, 13'h0, 32'hA5A5_0F0F, 1, "R11 mask output");

        // R12 unmapped address
        wr(13'h1010, 32'hFFFF_FFFF);
        expect_v(K_RD, 13'h1010, 32'h0, 1, "R12 unmapped reads zero");
        expect_v(K_RD, 13'h101C, 32'hA5A5_0F0F, 1, "R12 mask untouched");
        expect_v(K_RD, 13'h1000, 32'h0, 1, "R12 ctrl untouched");
        expect_v(K_RD, 13'h1004, 32'h0, 1, "R12 pend untouched");
        idle();
        idle();

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done_flag = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule